// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a page table tree that lives in an external memory. A base input gives the physical address of the top-level table, called the directory. The walker reads one 32-bit directory entry. That entry either maps a 4 MB region directly or points at a second-level table, which is then read to map a 4 KB page. Each walk takes one or two memory reads, and the number depends on the directory entry.

The walker talks to memory through a single-pulse read request and a later response strobe carrying the entry data. It accepts a new translation only while it is idle. Every walk ends with a one-cycle result. The result carries either the physical address or a fault with a cause code, and the linear address that started the walk is returned with it. Entries that are absent raise a not-present fault. A write through an entry that does not allow writing raises a protection fault.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready` is 1, `done_valid` is 0 and `mem_rd_valid` is 0.
- R2: A request is taken only when `req_ready` is 1, and `req_ready` is 1 only when the walker is idle. Changes on `req_valid`, `req_vaddr` and `req_write` during a walk have no effect on that walk's result.
- R3: At the edge that accepts a request, `mem_rd_valid` is raised for exactly one cycle, with `mem_rd_addr` = `dir_base` + 4 × linear address bits [31:22].
- R4: When the directory entry is present (bit 0 = 1), does not map a large page (bit 7 = 0) and raises no fault, a second read is issued at `mem_rd_addr` = {entry[31:12], 12'b0} + 4 × linear bits [21:12]. A fault-free result is `done_paddr` = {table entry[31:12], linear bits [11:0]}.
- R5: A present directory entry with bit 7 = 1 ends the walk after one read, with `done_paddr` = {entry[31:22], linear bits [21:0]}. Bit 7 of a second-level entry has no meaning.
- R6: An entry with bit 0 = 0 at either level ends the walk with `done_fault` = 1 and `done_cause` = 2'd1 (not present). At the directory level no second read is made.
- R7: For a write request (`req_write` = 1), a present entry at either level with bit 1 = 0 ends the walk with `done_fault` = 1 and `done_cause` = 2'd2 (protection). A read request ignores bit 1. Not-present has priority over protection.
- R8: Each result holds `done_valid` high for exactly one cycle. `done_vaddr` equals the accepted linear address. A successful walk gives `done_fault` = 0 and `done_cause` = 2'd0. A faulting walk gives `done_paddr` = 0.
- R9: `done_valid` rises at the same edge that samples the final `mem_rsp_valid`. The table read is issued at the edge that samples the directory response. No cycles are added beyond the memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is a write access |
| dir_base | input | 32 | Physical address of the directory |
| mem_rd_valid | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 32 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_data | input | 32 | Entry returned by memory |
| done_valid | output | 1 | Result strobe, one cycle |
| done_fault | output | 1 | Walk ended in a fault |
| done_cause | output | 2 | 0 none, 1 not present, 2 protection |
| done_paddr | output | 32 | Translated physical address, 0 on fault |
| done_vaddr | output | 32 | Linear address of the finished walk |

## Verification
The memory model answers each read a chosen latency L after the request, with L varied from 1 to 3 cycles. Counting from the accepting edge, a result is therefore due on the sampling point (reads × (L+1) + 1) cycles later. A walk that ends at the directory has one read and a full walk has two. The bench samples on falling edges and counts them from acceptance. It demands that `done_valid` appear exactly at that count, absent earlier, and gone again on the next sample. The sweep covers every directory index with two table indices and both access kinds. From arithmetic rules for entry contents, the bench predicts the read addresses, the read count, the fault cause and the physical address.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_READ_DIR   = 2'd1,
    ST_READ_TABLE = 2'd2,
    ST_DONE       = 2'd3
  } walk_state_t;

  typedef enum logic [1:0] {
    CAUSE_NONE        = 2'd0,
    CAUSE_NOT_PRESENT = 2'd1,
    CAUSE_PROTECT     = 2'd2
  } fault_cause_t;

endpackage

// File: rtl/pt_entry_addr.sv
// Entry address = table base + index scaled by entry size.
module pt_entry_addr #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 10,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] scaled;

  generate
    if (ENTRY_SHIFT == 0) begin : g_unscaled
      assign scaled = ADDR_W'(idx_i);
    end else begin : g_scaled
      assign scaled = ADDR_W'({idx_i, {ENTRY_SHIFT{1'b0}}});
    end
  endgenerate

  assign addr_o = base_i + scaled;
endmodule

// File: rtl/pt_entry_check.sv
// Decodes one fetched entry: permission check and address composition.
module pt_entry_check
  import pt_walker_pkg::*;
#(
  parameter int ENTRY_W     = 32,
  parameter int PA_W        = 32,
  parameter int TBL_IDX_W   = 10,
  parameter int PAGE_OFF_W  = 12,
  parameter int PRESENT_BIT = 0,
  parameter int WRITE_BIT   = 1,
  parameter int LARGE_BIT   = 7
) (
  input  logic [ENTRY_W-1:0]              entry_i,
  input  logic                            is_dir_i,
  input  logic                            write_i,
  input  logic [TBL_IDX_W+PAGE_OFF_W-1:0] low_va_i,
  output logic                            large_o,
  output logic                            fault_o,
  output fault_cause_t                    cause_o,
  output logic [PA_W-1:0]                 next_base_o,
  output logic [PA_W-1:0]                 small_pa_o,
  output logic [PA_W-1:0]                 large_pa_o
);
  localparam int LARGE_OFF_W   = TBL_IDX_W + PAGE_OFF_W;
  localparam int SMALL_FRAME_W = PA_W - PAGE_OFF_W;
  localparam int LARGE_FRAME_W = PA_W - LARGE_OFF_W;

  logic present;
  logic writable;

  assign present  = entry_i[PRESENT_BIT];
  assign writable = entry_i[WRITE_BIT];
  assign large_o  = is_dir_i && present && entry_i[LARGE_BIT];

  always_comb begin
    if (!present) begin
      cause_o = CAUSE_NOT_PRESENT;
    end else if (write_i && !writable) begin
      cause_o = CAUSE_PROTECT;
    end else begin
      cause_o = CAUSE_NONE;
    end
  end

  assign fault_o = (cause_o != CAUSE_NONE);

  assign next_base_o = {entry_i[ENTRY_W-1 -: SMALL_FRAME_W], {PAGE_OFF_W{1'b0}}};
  assign small_pa_o  = {entry_i[ENTRY_W-1 -: SMALL_FRAME_W], low_va_i[PAGE_OFF_W-1:0]};
  assign large_pa_o  = {entry_i[ENTRY_W-1 -: LARGE_FRAME_W], low_va_i[LARGE_OFF_W-1:0]};

  always_comb begin
    AST_PROTECT_NEEDS_PRESENT: assert (!(cause_o == CAUSE_PROTECT && !present)); // R7
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int DIR_IDX_W   = 10,
  parameter int TBL_IDX_W   = 10,
  parameter int PAGE_OFF_W  = 12,
  parameter int PA_W        = 32,
  parameter int ENTRY_W     = 32,
  parameter int ENTRY_SHIFT = 2,
  parameter int PRESENT_BIT = 0,
  parameter int WRITE_BIT   = 1,
  parameter int LARGE_BIT   = 7
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      req_valid,
  output logic                                      req_ready,
  input  logic [DIR_IDX_W+TBL_IDX_W+PAGE_OFF_W-1:0] req_vaddr,
  input  logic                                      req_write,
  input  logic [PA_W-1:0]                           dir_base,
  output logic                                      mem_rd_valid,
  output logic [PA_W-1:0]                           mem_rd_addr,
  input  logic                                      mem_rsp_valid,
  input  logic [ENTRY_W-1:0]                        mem_rsp_data,
  output logic                                      done_valid,
  output logic                                      done_fault,
  output logic [1:0]                                done_cause,
  output logic [PA_W-1:0]                           done_paddr,
  output logic [DIR_IDX_W+TBL_IDX_W+PAGE_OFF_W-1:0] done_vaddr
);
  localparam int VA_W        = DIR_IDX_W + TBL_IDX_W + PAGE_OFF_W;
  localparam int LARGE_OFF_W = TBL_IDX_W + PAGE_OFF_W;

  walk_state_t      state;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;

  logic [PA_W-1:0]  dir_addr;
  logic [PA_W-1:0]  tbl_addr;
  logic [PA_W-1:0]  next_base;
  logic [PA_W-1:0]  small_pa;
  logic [PA_W-1:0]  large_pa;
  logic             chk_large;
  logic             chk_fault;
  fault_cause_t     chk_cause;

  logic             finish;
  logic             issue_tbl;
  logic [PA_W-1:0]  fin_pa;
  fault_cause_t     fin_cause;

  pt_entry_addr #(
    .ADDR_W(PA_W), .IDX_W(DIR_IDX_W), .ENTRY_SHIFT(ENTRY_SHIFT)
  ) u_dir_addr (
    .base_i(dir_base),
    .idx_i (req_vaddr[VA_W-1 -: DIR_IDX_W]),
    .addr_o(dir_addr)
  );

  pt_entry_addr #(
    .ADDR_W(PA_W), .IDX_W(TBL_IDX_W), .ENTRY_SHIFT(ENTRY_SHIFT)
  ) u_tbl_addr (
    .base_i(next_base),
    .idx_i (va_q[PAGE_OFF_W +: TBL_IDX_W]),
    .addr_o(tbl_addr)
  );

  pt_entry_check #(
    .ENTRY_W(ENTRY_W), .PA_W(PA_W), .TBL_IDX_W(TBL_IDX_W),
    .PAGE_OFF_W(PAGE_OFF_W), .PRESENT_BIT(PRESENT_BIT),
    .WRITE_BIT(WRITE_BIT), .LARGE_BIT(LARGE_BIT)
  ) u_check (
    .entry_i    (mem_rsp_data),
    .is_dir_i   (state == ST_READ_DIR),
    .write_i    (wr_q),
    .low_va_i   (va_q[LARGE_OFF_W-1:0]),
    .large_o    (chk_large),
    .fault_o    (chk_fault),
    .cause_o    (chk_cause),
    .next_base_o(next_base),
    .small_pa_o (small_pa),
    .large_pa_o (large_pa)
  );

  assign req_ready = (state == ST_IDLE);

  // Decide the outcome of the response sampled this cycle.
  always_comb begin
    finish    = 1'b0;
    issue_tbl = 1'b0;
    fin_pa    = '0;
    fin_cause = CAUSE_NONE;
    unique case (state)
      ST_READ_DIR: begin
        if (mem_rsp_valid) begin
          if (chk_fault) begin
            finish    = 1'b1;
            fin_cause = chk_cause;
          end else if (chk_large) begin
            finish = 1'b1;
            fin_pa = large_pa;
          end else begin
            issue_tbl = 1'b1;
          end
        end
      end
      ST_READ_TABLE: begin
        if (mem_rsp_valid) begin
          finish = 1'b1;
          if (chk_fault) begin
            fin_cause = chk_cause;
          end else begin
            fin_pa = small_pa;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      va_q         <= '0;
      wr_q         <= 1'b0;
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
      done_valid   <= 1'b0;
      done_fault   <= 1'b0;
      done_cause   <= CAUSE_NONE;
      done_paddr   <= '0;
      done_vaddr   <= '0;
    end else begin
      mem_rd_valid <= 1'b0;
      done_valid   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q         <= req_vaddr;
            wr_q         <= req_write;
            mem_rd_valid <= 1'b1;
            mem_rd_addr  <= dir_addr;
            state        <= ST_READ_DIR;
          end
        end
        ST_READ_DIR, ST_READ_TABLE: begin
          if (issue_tbl) begin
            mem_rd_valid <= 1'b1;
            mem_rd_addr  <= tbl_addr;
            state        <= ST_READ_TABLE;
          end else if (finish) begin
            done_valid <= 1'b1;
            done_fault <= (fin_cause != CAUSE_NONE);
            done_cause <= fin_cause;
            done_paddr <= fin_pa;
            done_vaddr <= va_q;
            state      <= ST_DONE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_rd_valid && !req_ready)); // R2
  AST_READ_IS_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |=> !mem_rd_valid); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> (!done_valid && req_ready)); // R8
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_fault) |-> (done_paddr == '0)); // R8
  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (done_fault == (done_cause != 2'd0))); // R6
  AST_DONE_ON_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    $rose(done_valid) |-> $past(mem_rsp_valid)); // R9
  AST_NO_READ_WHILE_DONE: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> !mem_rd_valid); // R5
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  localparam logic [31:0] DIR_BASE = 32'h0010_0000;
  localparam logic [31:0] TBL_REGION = 32'h0020_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done_valid;
  logic        done_fault;
  logic [1:0]  done_cause;
  logic [31:0] done_paddr;
  logic [31:0] done_vaddr;

  int checks = 0;
  int failures = 0;
  int lat = 1;
  int rd_count = 0;
  logic [31:0] rd_addr0, rd_addr1;

  always #10 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write),
    .dir_base(DIR_BASE),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_fault(done_fault),
    .done_cause(done_cause), .done_paddr(done_paddr),
    .done_vaddr(done_vaddr)
  );

  function automatic logic [31:0] dir_entry(int d);
    logic [31:0] e = '0;
    logic [9:0]  dd = 10'(d);
    e[0]   = (d % 7) != 3;
    e[1]   = (d % 3) != 1;
    e[6:2] = dd[4:0];
    if ((d % 5) == 2) begin
      e[7]     = 1'b1;
      e[31:22] = dd ^ 10'h2A5;
    end else begin
      e[31:12] = 20'h00200 + 20'(d);
    end
    return e;
  endfunction

  function automatic logic [31:0] tbl_entry(int d, int t);
    logic [31:0] e = '0;
    e[0]     = ((d + t) % 11) != 5;
    e[1]     = ((d ^ t) & 3) != 0;
    e[7]     = d[0];
    e[31:12] = 20'((d * 1031 + t * 17) & 32'hFFFFF);
    return e;
  endfunction

  function automatic logic [31:0] mem_lookup(logic [31:0] a);
    if (a >= DIR_BASE && a < DIR_BASE + 32'd4096)
      return dir_entry(int'((a - DIR_BASE) >> 2));
    if (a >= TBL_REGION && a < TBL_REGION + 32'h0040_0000)
      return tbl_entry(int'((a - TBL_REGION) >> 12), int'((a >> 2) & 32'h3FF));
    return 32'hDEAD_0000;
  endfunction

  // Memory model: answers each read lat cycles after the request.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        logic [31:0] a;
        a = mem_rd_addr;
        if (rd_count == 0) rd_addr0 = a;
        else rd_addr1 = a;
        rd_count++;
        repeat (lat) @(posedge clk);
        #1;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_lookup(a);
        @(posedge clk);
        #1;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
      end
    end
  end

  task automatic check(string req, logic ok, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walk(int d, int t, logic wr, logic busy);
    logic [31:0] va, pde, pte, exp_pa;
    logic [1:0]  exp_cause;
    int          exp_reads, cyc;
    logic        early_ready;
    va  = {10'(d), 10'(t), 12'((d * 37 + t * 5) & 32'hFFF)};
    pde = dir_entry(d);
    pte = tbl_entry(d, t);
    exp_pa = '0;
    exp_cause = 2'd0;
    exp_reads = 1;
    if (!pde[0]) exp_cause = 2'd1;
    else if (wr && !pde[1]) exp_cause = 2'd2;
    else if (pde[7]) exp_pa = {pde[31:22], va[21:0]};
    else begin
      exp_reads = 2;
      if (!pte[0]) exp_cause = 2'd1;
      else if (wr && !pte[1]) exp_cause = 2'd2;
      else exp_pa = {pte[31:12], va[11:0]};
    end

    rd_count  = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    req_write = wr;
    @(posedge clk);
    #1;
    if (busy) begin
      req_vaddr = ~va;          // R2: must be ignored mid-walk
      req_write = ~wr;
    end else begin
      req_valid = 1'b0;
    end
    cyc = 0;
    early_ready = 1'b0;
    do begin
      @(negedge clk);
      cyc++;
      if (req_ready && !done_valid) early_ready = 1'b1;
    end while (!done_valid && cyc < 200);
    req_valid = 1'b0;

    check("R2 busy walker not ready", !early_ready, 32'(early_ready), 32'd0);
    check("R9 result cycle", cyc == exp_reads * (lat + 1) + 1, 32'(cyc),
          32'(exp_reads * (lat + 1) + 1));
    check("R3 directory read address", rd_addr0 == DIR_BASE + 32'(d * 4), rd_addr0,
          DIR_BASE + 32'(d * 4));
    if (exp_reads == 2)
      check("R4 table read address", rd_addr1 == {pde[31:12], 12'h000} + 32'(t * 4),
            rd_addr1, {pde[31:12], 12'h000} + 32'(t * 4));
    if (pde[0] && pde[7])
      check("R5 large page read count", rd_count == exp_reads, 32'(rd_count), 32'(exp_reads));
    else
      check("R6 read count", rd_count == exp_reads, 32'(rd_count), 32'(exp_reads));
    if (exp_cause == 2'd2)
      check("R7 protection cause", done_cause == 2'd2 && done_fault, 32'(done_cause), 32'd2);
    else if (exp_cause == 2'd1)
      check("R6 not-present cause", done_cause == 2'd1 && done_fault, 32'(done_cause), 32'd1);
    else
      check("R8 no fault", done_cause == 2'd0 && !done_fault, 32'(done_cause), 32'd0);
    if (pde[0] && pde[7])
      check("R5 large page address", done_paddr == exp_pa, done_paddr, exp_pa);
    else
      check("R4 physical address", done_paddr == exp_pa, done_paddr, exp_pa);
    check("R8 linear address returned", done_vaddr == va, done_vaddr, va);
    @(negedge clk);
    check("R8 result lasts one cycle", !done_valid && req_ready,
          {30'd0, done_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ready", req_ready == 1'b1, 32'(req_ready), 32'd1);
    check("R1 reset no result", done_valid == 1'b0, 32'(done_valid), 32'd0);
    check("R1 reset no read", mem_rd_valid == 1'b0, 32'(mem_rd_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset idle", req_ready && !done_valid && !mem_rd_valid,
          {29'd0, req_ready, done_valid, mem_rd_valid}, 32'd4);
    for (int d = 0; d < 1024; d++) begin
      for (int k = 0; k < 4; k++) begin
        int t;
        t   = k[1] ? (1023 - d) : ((d * 7) & 1023);
        lat = 1 + (d + k) % 3;
        walk(d, t, k[0], (d % 4) == 0);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule